// File: doc/BRIEF.md
# CAN Controller Interrupt Priority Coder

This block holds the interrupt flags of a CAN controller and turns them, together with their enable bits, into two outputs. One is a single interrupt request. The other is a short code that names the most urgent source that is both pending and enabled. Software writes to the flags are modelled as per-source set and clear strobes. The sources are the transmit buffers, the receive buffers, wake-up and one shared error flag. The error flag is fed by six error causes: receiver overrun, receiver warning, receiver error-passive, transmitter warning, transmitter error-passive and bus-off. Each cause also stays readable in its own sticky status bit.

A two-bit mode input chooses how the code is formed. In legacy mode (0) every buffer has its own enable and its own code value, and the code is three bits wide. In grouped mode (1) one enable covers all transmit buffers and another covers all receive buffers, and the code uses the five-bit extended format. FIFO mode (2, with 3 as an alias) works like grouped mode, except that any pending receive reports the fixed value 16 (binary 10000). Smaller code values always mean higher priority, and zero means nothing is pending.

The request output is driven by a two-state machine. IRQ_IDLE moves to IRQ_ACTIVE on the RAISE transition, taken when any enabled source is pending at a clock edge. IRQ_ACTIVE returns to IRQ_IDLE on the DROP transition, taken when no enabled source is pending. Each state holds itself (the HOLD transition) otherwise.

Top module: `icode_encoder`

## Requirements
- R1: While reset is active and right after it, all flags, the cause status, code_o and irq_o are zero.
- R2: A set strobe makes its flag 1 at the next clock edge and a clear strobe makes it 0. When set and clear arrive together, set wins. With no strobe the flag holds its value.
- R3: Any bit of err_set_i sets the shared error flag. The matching bit of err_cause_o is also set and stays set until its own cause_clr_i bit, even when err_clr_i clears the shared flag.
- R4: With mode 0 and the default sizes, code_o is: 0 none, 1 error, 2/3/4 transmit buffer 2/1/0, 5/6 receive buffer 1/0, 7 wake-up. The lowest value among the pending sources is shown.
- R5: Only enabled sources count toward the code and the request. In mode 0 the per-buffer enables tx_en_i/rx_en_i apply and the group enables have no effect. A flag set while its source is disabled appears as soon as the enable rises.
- R6: With mode 1, code_o is: 0 none, 1 error, 2 any transmit flag with tx_grp_en_i, 3 any receive flag with rx_grp_en_i, 4 wake-up. The per-buffer enables have no effect.
- R7: With mode 2 or 3, code_o follows R6 except that the receive group reports 16. Error and transmit still take precedence over it.
- R8: code_o reflects the flags with no added register. After the top pending source is cleared, the code shows the next pending source at the edge where the clear takes effect.
- R9: irq_o rises one cycle after code_o becomes nonzero and falls one cycle after code_o becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 legacy, 1 grouped, 2/3 FIFO |
| tx_set_i | input | NTX | Transmit buffer flag set strobes |
| tx_clr_i | input | NTX | Transmit buffer flag clear strobes |
| rx_set_i | input | NRX | Receive buffer flag set strobes |
| rx_clr_i | input | NRX | Receive buffer flag clear strobes |
| wake_set_i | input | 1 | Wake-up flag set strobe |
| wake_clr_i | input | 1 | Wake-up flag clear strobe |
| err_set_i | input | 6 | Error cause strobes (overrun, rx warn, rx passive, tx warn, tx passive, bus-off) |
| err_clr_i | input | 1 | Shared error flag clear strobe |
| cause_clr_i | input | 6 | Per-cause status clear strobes |
| tx_en_i | input | NTX | Per-buffer transmit enables (legacy mode) |
| rx_en_i | input | NRX | Per-buffer receive enables (legacy mode) |
| tx_grp_en_i | input | 1 | Transmit group enable (grouped/FIFO modes) |
| rx_grp_en_i | input | 1 | Receive group enable (grouped/FIFO modes) |
| wake_en_i | input | 1 | Wake-up enable |
| err_en_i | input | 1 | Error enable |
| err_cause_o | output | 6 | Sticky error cause status |
| code_o | output | 5 | Priority code, lower is more urgent, 0 none |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Some behaviour is checked by the assertions on every cycle. These cover set-over-clear and hold on each flag bit, error taking code 1 one edge after a cause strobe, the code staying inside the legacy width, FIFO mode producing only its legal values, and the request following the code with one cycle of delay. Only the bench's scenarios can show the exact code for each mix of sources in each mode, that masked sources and the unused set of enables have no effect, and how the code walks down to the next source as flags are cleared. The same applies to cause status bits that outlive a clear of the shared flag.

// File: rtl/icode_pkg.sv
package icode_pkg;

    localparam int CODE_W  = 5;
    localparam int NUM_ERR = 6;

    typedef enum logic [1:0] {
        MODE_LEGACY   = 2'd0,
        MODE_GROUPED  = 2'd1,
        MODE_FIFO     = 2'd2,
        MODE_FIFO_ALT = 2'd3
    } icode_mode_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    localparam logic [CODE_W-1:0] EXT_NONE    = 5'd0;
    localparam logic [CODE_W-1:0] EXT_ERR     = 5'd1;
    localparam logic [CODE_W-1:0] EXT_TX      = 5'd2;
    localparam logic [CODE_W-1:0] EXT_RX      = 5'd3;
    localparam logic [CODE_W-1:0] EXT_WAKE    = 5'd4;
    localparam logic [CODE_W-1:0] EXT_FIFO_RX = 5'd16;

endpackage

// File: rtl/icode_flags.sv
module icode_flags #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic flag_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_i[b]) begin
                flag_q <= 1'b1;
            end else if (clr_i[b]) begin
                flag_q <= 1'b0;
            end
        end

        assign flag_o[b] = flag_q;

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> flag_o[b]); // R2
        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !flag_o[b]); // R2
        AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[b] && !set_i[b]) |=> (flag_o[b] == $past(flag_o[b]))); // R2
    end

endmodule

// File: rtl/icode_prio.sv
module icode_prio
    import icode_pkg::*;
#(
    parameter int NTX   = 3,
    parameter int NRX   = 2,
    parameter int LEG_W = 3
) (
    input  icode_mode_e        mode_i,
    input  logic [NTX-1:0]     tx_flag_i,
    input  logic [NRX-1:0]     rx_flag_i,
    input  logic               wake_flag_i,
    input  logic               err_flag_i,
    input  logic [NTX-1:0]     tx_en_i,
    input  logic [NRX-1:0]     rx_en_i,
    input  logic               tx_grp_en_i,
    input  logic               rx_grp_en_i,
    input  logic               wake_en_i,
    input  logic               err_en_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               pend_o
);

    localparam int NS = NTX + NRX + 2;

    logic [NS-1:0]    leg_vec;
    logic [LEG_W-1:0] leg_code;
    logic             err_hit;
    logic             wake_hit;
    logic             tx_any;
    logic             rx_any;
    logic [CODE_W-1:0] ext_rx_code;

    assign err_hit  = err_flag_i  & err_en_i;
    assign wake_hit = wake_flag_i & wake_en_i;
    assign tx_any   = tx_grp_en_i & (|tx_flag_i);
    assign rx_any   = rx_grp_en_i & (|rx_flag_i);

    // Legacy ordering: slot 0 error, then transmit high to low, receive high to low, wake last
    always_comb begin
        leg_vec          = '0;
        leg_vec[0]       = err_hit;
        leg_vec[NS-1]    = wake_hit;
        for (int t = 0; t < NTX; t++) begin
            leg_vec[1 + (NTX - 1 - t)] = tx_flag_i[t] & tx_en_i[t];
        end
        for (int r = 0; r < NRX; r++) begin
            leg_vec[1 + NTX + (NRX - 1 - r)] = rx_flag_i[r] & rx_en_i[r];
        end
    end

    always_comb begin
        leg_code = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (leg_vec[i]) begin
                leg_code = LEG_W'(i + 1);
            end
        end
    end

    always_comb begin
        ext_rx_code = (mode_i == MODE_GROUPED) ? EXT_RX : EXT_FIFO_RX;
        code_o      = EXT_NONE;
        pend_o      = 1'b0;
        unique case (mode_i)
            MODE_LEGACY: begin
                code_o = CODE_W'(leg_code);
                pend_o = |leg_vec;
            end
            MODE_GROUPED, MODE_FIFO, MODE_FIFO_ALT: begin
                pend_o = err_hit | tx_any | rx_any | wake_hit;
                if (err_hit) begin
                    code_o = EXT_ERR;
                end else if (tx_any) begin
                    code_o = EXT_TX;
                end else if (rx_any) begin
                    code_o = ext_rx_code;
                end else if (wake_hit) begin
                    code_o = EXT_WAKE;
                end
            end
        endcase
    end

endmodule

// File: rtl/icode_encoder.sv
module icode_encoder
    import icode_pkg::*;
#(
    parameter int NTX = 3,
    parameter int NRX = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic [NTX-1:0]     tx_set_i,
    input  logic [NTX-1:0]     tx_clr_i,
    input  logic [NRX-1:0]     rx_set_i,
    input  logic [NRX-1:0]     rx_clr_i,
    input  logic               wake_set_i,
    input  logic               wake_clr_i,
    input  logic [NUM_ERR-1:0] err_set_i,
    input  logic               err_clr_i,
    input  logic [NUM_ERR-1:0] cause_clr_i,
    input  logic [NTX-1:0]     tx_en_i,
    input  logic [NRX-1:0]     rx_en_i,
    input  logic               tx_grp_en_i,
    input  logic               rx_grp_en_i,
    input  logic               wake_en_i,
    input  logic               err_en_i,
    output logic [NUM_ERR-1:0] err_cause_o,
    output logic [CODE_W-1:0]  code_o,
    output logic               irq_o
);

    localparam int LEG_W = $clog2(NTX + NRX + 3);

    icode_mode_e    mode_e;
    logic [NTX-1:0] tx_flag;
    logic [NRX-1:0] rx_flag;
    logic           wake_flag;
    logic           err_flag;
    logic           pend;
    irq_state_e     state_q;
    irq_state_e     state_d;

    assign mode_e = icode_mode_e'(mode_i);

    icode_flags #(.W(NTX)) u_tx_flags (
        .clk(clk), .rst_n(rst_n), .set_i(tx_set_i), .clr_i(tx_clr_i), .flag_o(tx_flag)
    );

    icode_flags #(.W(NRX)) u_rx_flags (
        .clk(clk), .rst_n(rst_n), .set_i(rx_set_i), .clr_i(rx_clr_i), .flag_o(rx_flag)
    );

    icode_flags #(.W(1)) u_wake_flag (
        .clk(clk), .rst_n(rst_n), .set_i(wake_set_i), .clr_i(wake_clr_i), .flag_o(wake_flag)
    );

    icode_flags #(.W(1)) u_err_flag (
        .clk(clk), .rst_n(rst_n), .set_i(|err_set_i), .clr_i(err_clr_i), .flag_o(err_flag)
    );

    icode_flags #(.W(NUM_ERR)) u_cause (
        .clk(clk), .rst_n(rst_n), .set_i(err_set_i), .clr_i(cause_clr_i), .flag_o(err_cause_o)
    );

    icode_prio #(.NTX(NTX), .NRX(NRX), .LEG_W(LEG_W)) u_prio (
        .mode_i      (mode_e),
        .tx_flag_i   (tx_flag),
        .rx_flag_i   (rx_flag),
        .wake_flag_i (wake_flag),
        .err_flag_i  (err_flag),
        .tx_en_i     (tx_en_i),
        .rx_en_i     (rx_en_i),
        .tx_grp_en_i (tx_grp_en_i),
        .rx_grp_en_i (rx_grp_en_i),
        .wake_en_i   (wake_en_i),
        .err_en_i    (err_en_i),
        .code_o      (code_o),
        .pend_o      (pend)
    );

    // Request state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RAISE, DROP, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   state_d = pend ? IRQ_ACTIVE : IRQ_IDLE;
            IRQ_ACTIVE: state_d = pend ? IRQ_ACTIVE : IRQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_o = (state_q == IRQ_ACTIVE);
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != EXT_NONE) |=> irq_o); // R9
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == EXT_NONE) |=> !irq_o); // R9
    AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (err_en_i && (|err_set_i)) |=> (!err_en_i || code_o == EXT_ERR)); // R3
    AST_LEGACY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_LEGACY) |-> ((code_o >> LEG_W) == '0)); // R4
    AST_FIFO_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_FIFO || mode_e == MODE_FIFO_ALT) |->
        (code_o == EXT_NONE || code_o == EXT_ERR || code_o == EXT_TX ||
         code_o == EXT_WAKE || code_o == EXT_FIFO_RX)); // R7

endmodule

// File: tb/icode_encoder_tb.sv
module icode_encoder_tb;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] txs;
        logic [1:0] rxs;
        logic       wks;
        logic [5:0] errs;
        logic [2:0] txen;
        logic [1:0] rxen;
        logic       txg;
        logic       rxg;
        logic       wken;
        logic       eren;
        logic [4:0] code;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'b000, 2'b00, 1'b0, 6'b000000, 3'b111, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 5'd0},
        '{2'd0, 3'b000, 2'b00, 1'b1, 6'b000000, 3'b000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd7},
        '{2'd0, 3'b000, 2'b01, 1'b1, 6'b000000, 3'b000, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 5'd6},
        '{2'd0, 3'b000, 2'b11, 1'b0, 6'b000000, 3'b000, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 5'd5},
        '{2'd0, 3'b001, 2'b10, 1'b0, 6'b000000, 3'b111, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4},
        '{2'd0, 3'b011, 2'b00, 1'b0, 6'b000000, 3'b111, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5'd3},
        '{2'd0, 3'b111, 2'b11, 1'b1, 6'b000000, 3'b111, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 5'd2},
        '{2'd0, 3'b100, 2'b00, 1'b0, 6'b001000, 3'b111, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1},
        '{2'd0, 3'b100, 2'b01, 1'b0, 6'b000000, 3'b011, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 5'd6},
        '{2'd0, 3'b000, 2'b00, 1'b1, 6'b000001, 3'b000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd7},
        '{2'd0, 3'b111, 2'b11, 1'b0, 6'b000000, 3'b000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0},
        '{2'd1, 3'b000, 2'b10, 1'b0, 6'b000000, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3},
        '{2'd1, 3'b001, 2'b01, 1'b0, 6'b000000, 3'b000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 5'd2},
        '{2'd1, 3'b010, 2'b00, 1'b0, 6'b100000, 3'b000, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 5'd1},
        '{2'd1, 3'b000, 2'b00, 1'b1, 6'b000000, 3'b000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 5'd4},
        '{2'd1, 3'b111, 2'b11, 1'b0, 6'b000000, 3'b111, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0},
        '{2'd2, 3'b000, 2'b01, 1'b0, 6'b000000, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd16},
        '{2'd2, 3'b000, 2'b10, 1'b1, 6'b000000, 3'b000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 5'd16},
        '{2'd2, 3'b100, 2'b01, 1'b0, 6'b000000, 3'b000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 5'd2},
        '{2'd3, 3'b000, 2'b01, 1'b0, 6'b000000, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 5'd16},
        '{2'd2, 3'b000, 2'b00, 1'b1, 6'b000000, 3'b000, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 5'd4},
        '{2'd2, 3'b000, 2'b11, 1'b0, 6'b010000, 3'b000, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 5'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = '0;
    logic [2:0] tx_set_i = '0, tx_clr_i = '0, tx_en_i = '0;
    logic [1:0] rx_set_i = '0, rx_clr_i = '0, rx_en_i = '0;
    logic       wake_set_i = 1'b0, wake_clr_i = 1'b0;
    logic [5:0] err_set_i = '0, cause_clr_i = '0;
    logic       err_clr_i = 1'b0;
    logic       tx_grp_en_i = 1'b0, rx_grp_en_i = 1'b0, wake_en_i = 1'b0, err_en_i = 1'b0;
    logic [5:0] err_cause_o;
    logic [4:0] code_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    icode_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .tx_set_i(tx_set_i), .tx_clr_i(tx_clr_i),
        .rx_set_i(rx_set_i), .rx_clr_i(rx_clr_i),
        .wake_set_i(wake_set_i), .wake_clr_i(wake_clr_i),
        .err_set_i(err_set_i), .err_clr_i(err_clr_i), .cause_clr_i(cause_clr_i),
        .tx_en_i(tx_en_i), .rx_en_i(rx_en_i),
        .tx_grp_en_i(tx_grp_en_i), .rx_grp_en_i(rx_grp_en_i),
        .wake_en_i(wake_en_i), .err_en_i(err_en_i),
        .err_cause_o(err_cause_o), .code_o(code_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        tx_set_i = '0; rx_set_i = '0; wake_set_i = 1'b0; err_set_i = '0;
        tx_clr_i = '1; rx_clr_i = '1; wake_clr_i = 1'b1; err_clr_i = 1'b1; cause_clr_i = '1;
        @(negedge clk);
        tx_clr_i = '0; rx_clr_i = '0; wake_clr_i = 1'b0; err_clr_i = 1'b0; cause_clr_i = '0;
    endtask

    task automatic idle_strobes();
        tx_set_i = '0; rx_set_i = '0; wake_set_i = 1'b0; err_set_i = '0;
        tx_clr_i = '0; rx_clr_i = '0; wake_clr_i = 1'b0; err_clr_i = 1'b0; cause_clr_i = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        string tag;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "code in reset", 8'(code_o), 8'd0);
        check("R1", "irq in reset", 8'(irq_o), 8'd0);
        check("R1", "cause in reset", 8'(err_cause_o), 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "code after reset", 8'(code_o), 8'd0);

        // Vector walk (R4 legacy, R5 masking, R6 grouped, R7 FIFO)
        for (int v = 0; v < NV; v++) begin
            clear_all();
            mode_i = VECS[v].mode;
            tx_set_i = VECS[v].txs; rx_set_i = VECS[v].rxs;
            wake_set_i = VECS[v].wks; err_set_i = VECS[v].errs;
            tx_en_i = VECS[v].txen; rx_en_i = VECS[v].rxen;
            tx_grp_en_i = VECS[v].txg; rx_grp_en_i = VECS[v].rxg;
            wake_en_i = VECS[v].wken; err_en_i = VECS[v].eren;
            @(negedge clk);
            idle_strobes();
            tag = (VECS[v].mode == 2'd0) ? "R4/R5" : (VECS[v].mode == 2'd1) ? "R6" : "R7";
            check(tag, $sformatf("code vec %0d", v), 8'(code_o), 8'(VECS[v].code));
            @(negedge clk);
            check("R9", $sformatf("irq vec %0d", v), 8'(irq_o), 8'(VECS[v].code != 5'd0));
        end

        // R2: set and clear together, set wins
        clear_all();
        mode_i = 2'd0; tx_en_i = 3'b111; rx_en_i = 2'b11; wake_en_i = 1'b1; err_en_i = 1'b1;
        tx_grp_en_i = 1'b0; rx_grp_en_i = 1'b0;
        tx_set_i = 3'b001; tx_clr_i = 3'b001;
        @(negedge clk);
        idle_strobes();
        check("R2", "set beats clear", 8'(code_o), 8'd4);
        repeat (2) @(negedge clk);
        check("R2", "flag holds", 8'(code_o), 8'd4);
        tx_clr_i = 3'b001;
        @(negedge clk);
        idle_strobes();
        check("R2", "clear alone", 8'(code_o), 8'd0);

        // R8 / R9: walk down priorities as flags are cleared
        clear_all();
        err_set_i = 6'b000010; tx_set_i = 3'b100;
        @(negedge clk);
        idle_strobes();
        check("R8", "error on top", 8'(code_o), 8'd1);
        check("R9", "irq not yet", 8'(irq_o), 8'd0);
        @(negedge clk);
        check("R9", "irq raised", 8'(irq_o), 8'd1);
        err_clr_i = 1'b1;
        @(negedge clk);
        idle_strobes();
        check("R8", "next is tx2", 8'(code_o), 8'd2);
        tx_clr_i = 3'b100;
        @(negedge clk);
        idle_strobes();
        check("R8", "none left", 8'(code_o), 8'd0);
        check("R9", "irq still high", 8'(irq_o), 8'd1);
        @(negedge clk);
        check("R9", "irq dropped", 8'(irq_o), 8'd0);

        // R3: sticky cause bits
        clear_all();
        err_set_i = 6'b100100;
        @(negedge clk);
        idle_strobes();
        check("R3", "causes set", 8'(err_cause_o), 8'b00100100);
        check("R3", "shared flag code", 8'(code_o), 8'd1);
        err_clr_i = 1'b1;
        @(negedge clk);
        idle_strobes();
        check("R3", "shared flag cleared", 8'(code_o), 8'd0);
        check("R3", "causes survive", 8'(err_cause_o), 8'b00100100);
        cause_clr_i = 6'b000100;
        @(negedge clk);
        idle_strobes();
        check("R3", "one cause cleared", 8'(err_cause_o), 8'b00100000);

        // R5: flag set while disabled shows when enabled
        clear_all();
        err_en_i = 1'b0;
        err_set_i = 6'b000001;
        @(negedge clk);
        idle_strobes();
        check("R5", "disabled error hidden", 8'(code_o), 8'd0);
        err_en_i = 1'b1;
        #1;
        check("R5", "enabled error shown", 8'(code_o), 8'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule